// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a general-purpose timer on a small word-addressed register bus. An up-counter advances once per step. A step comes on every bus clock, or on every sixteenth bus clock when the divided clock is selected. The count is compared with a programmable reference value. The step that leaves the reference value counts as a match.

A match latches a reference event flag. When the interrupt enable is set, that flag also drives a level interrupt output. The counter then does one of two things. In restart mode it returns to zero, so a period lasts reference+1 steps. Otherwise it keeps counting and wraps at its full width. Software reads the live count at any time and acknowledges events by writing ones to the event register.

Register map (word index on `bus_addr`):

| Index | Register | Contents |
|-------|----------|----------|
| 0 | control | bit0 run, bit1 divide-by-16, bit2 restart, bit3 interrupt enable |
| 1 | reference | `REF_W` bits |
| 2 | count | low 16 bits of the counter |
| 3 | event | bit1 reference flag, bit0 capture flag (always reads 0) |

Top module: `refcmp_timer`

## Requirements
- R1: While control bit0 (run) is 0, the counter is held at zero. When run is 1, the counter advances by one on every step.
- R2: With control bit2 (restart) set, the counter goes 0, 1, ..., reference and then returns to 0 on the next step. Each period is reference+1 steps.
- R3: Control bit1 selects the step rate. At 0 a step comes on every clock. At 1 a step comes once every 16 clocks.
- R4: With restart clear, the counter passes the reference value and sets the reference flag at the match. It wraps to 0 after 2^REF_W − 1.
- R5: Event bit1 (reference flag) is set by the step that leaves the reference value. Event bit0 always reads 0.
- R6: Writing a 1 to event bit1 clears the flag. Writing a 0 leaves it unchanged. A match in the same cycle as a clearing write keeps the flag set.
- R7: `tmr_irq` is a level output. It is 1 exactly while the reference flag and control bit3 (interrupt enable) are both 1.
- R8: The prescaler is cleared while run is 0. After enabling with divide-by-16, the first step comes 16 clocks after the enabling write.
- R9: The count register reads the low 16 bits of the live counter at any time. Writes to it have no effect.
- R10: The reference register keeps `REF_W` bits. Higher write data bits are dropped, and reads return them as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| tmr_irq | output | 1 | Level interrupt |

## Verification
The counter is first run in restart mode with a small reference, clocked from the undivided clock. This shows that the period is reference+1 steps rather than reference steps. The same reference is then run without restart. In that mode the count must pass the reference, and a long run must show the wrap at full width, which tells the two counting modes apart. A run with the divided clock checks the 16-clock step, including the full first interval after enabling. Event writes of zero, of one, and of one in the same cycle as a match separate plain clearing from the rule that a match wins.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;

  typedef struct packed {
    logic irq_en;   // bit3
    logic restart;  // bit2
    logic div16;    // bit1
    logic run;      // bit0
  } ctrl_t;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_REF   = 2'd1,
    A_COUNT = 2'd2,
    A_EVENT = 2'd3
  } reg_addr_e;

  localparam int unsigned EVT_REF_BIT = 1;
  localparam int unsigned CNT_RD_MAX  = 16;

endpackage

// File: rtl/refcmp_prescale.sv
module refcmp_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_sel,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (!run)              pre_q <= '0;
    else if (pre_q == LAST)     pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (!div_sel || (pre_q == LAST));

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel) |=> (!tick || !div_sel)); // R3

endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] ref_val,
  output logic [W-1:0] cnt,
  output logic         match
);
  function automatic logic [W-1:0] step_count(input logic [W-1:0] cur,
                                               input logic hit,
                                               input logic wrap_mode);
    if (hit && wrap_mode) return '0;
    return cur + 1'b1;
  endfunction

  assign match = tick && (cnt == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= step_count(cnt, match, restart);
  end

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R1
  AST_WRAP_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (match && restart) |=> (cnt == '0)); // R2
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && (cnt == '1)) |=> (cnt == '0)); // R4

endmodule

// File: rtl/refcmp_flag.sv
module refcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_ev)  flag <= 1'b1;
    else if (clr_ev)  flag <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_ev) |=> flag); // R6

endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REF_W  = 16,
  parameter int unsigned DIV    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tmr_irq
);
  localparam int unsigned RD_W = (REF_W < CNT_RD_MAX) ? REF_W : CNT_RD_MAX;

  ctrl_t            ctrl_q;
  logic [REF_W-1:0] ref_q;
  logic [REF_W-1:0] cnt;
  logic             tick;
  logic             match;
  logic             ref_flag;
  logic             wr_ctrl;
  logic             wr_ref;
  logic             clr_ref;
  reg_addr_e        sel;

  assign sel     = reg_addr_e'(bus_addr[1:0]);
  assign wr_ctrl = bus_wr && (sel == A_CTRL);
  assign wr_ref  = bus_wr && (sel == A_REF);
  assign clr_ref = bus_wr && (sel == A_EVENT) && bus_wdata[EVT_REF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[3:0]);
      if (wr_ref)  ref_q  <= bus_wdata[REF_W-1:0];
    end
  end

  refcmp_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .div_sel(ctrl_q.div16), .tick(tick)
  );

  refcmp_counter #(.W(REF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick),
    .restart(ctrl_q.restart), .ref_val(ref_q), .cnt(cnt), .match(match)
  );

  refcmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(match), .clr_ev(clr_ref), .flag(ref_flag)
  );

  assign tmr_irq = ref_flag && ctrl_q.irq_en;

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_REF:   bus_rdata = DATA_W'(ref_q);
      A_COUNT: bus_rdata = DATA_W'(cnt[RD_W-1:0]);
      A_EVENT: bus_rdata = DATA_W'({ref_flag, 1'b0});
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !match && !wr_ctrl) |=> !tmr_irq); // R7
  AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (match && ctrl_q.irq_en && !wr_ctrl) |=> tmr_irq); // R7

endmodule

// File: tb/refcmp_timer_tb.sv
`timescale 1ns/1ps
module refcmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tmr_irq;

  int checks = 0;
  int errors = 0;
  int          q_req[$];
  logic [31:0] q_exp[$];
  logic [31:0] q_act[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  refcmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  localparam logic [31:0] RUN = 32'h1, DIV16 = 32'h2, RST = 32'h4, IEN = 32'h8;

  // monitor: pops scoreboard items and compares them
  always @(negedge clk) begin
    while (q_req.size() > 0) begin
      int r;
      logic [31:0] e, a;
      r = q_req.pop_front(); e = q_exp.pop_front(); a = q_act.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL R%0d actual=%h expected=%h", r, a, e);
      end
    end
  end

  task automatic push(input int r, input logic [31:0] e, input logic [31:0] a);
    q_req.push_back(r); q_exp.push_back(e); q_act.push_back(a);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int r, input logic [1:0] a, input logic [31:0] e);
    bus_addr = a;
    #1;
    push(r, e, bus_rdata);
  endtask

  task automatic irq_chk(input int r, input logic e);
    #1;
    push(r, {31'b0, e}, {31'b0, tmr_irq});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    // reset state
    rd(1, 2'd0, 32'h0);
    rd(1, 2'd2, 32'h0);            // R1 idle count
    rd(5, 2'd3, 32'h0);            // R5
    irq_chk(7, 1'b0);              // R7
    // R10: reference width
    wr(2'd1, 32'h0001_2345);
    rd(10, 2'd1, 32'h0000_2345);
    wr(2'd1, 32'd4);
    // R2: restart, ref 4, undivided
    wr(2'd0, RUN | RST);
    rd(1, 2'd2, 32'd0);            // R1
    wait_n(3);
    rd(2, 2'd2, 32'd3);            // R2
    wait_n(2);
    rd(2, 2'd2, 32'd0);            // R2 ref+1 steps
    rd(5, 2'd3, 32'h2);            // R5
    irq_chk(7, 1'b0);              // R7 disabled
    wr(2'd0, RUN | RST | IEN);     // cnt 1
    irq_chk(7, 1'b1);              // R7
    wr(2'd3, 32'h0);               // cnt 2, zero write ignored
    rd(6, 2'd3, 32'h2);            // R6
    wr(2'd3, 32'h2);               // cnt 3, clear
    rd(6, 2'd3, 32'h0);            // R6
    irq_chk(7, 1'b0);              // R7
    wait_n(1);                     // cnt 4
    rd(2, 2'd2, 32'd4);            // R2
    wr(2'd3, 32'h2);               // match same cycle as clear
    rd(6, 2'd3, 32'h2);            // R6 match wins
    rd(2, 2'd2, 32'd0);            // R2
    // R9: count not writable
    wr(2'd2, 32'h55);              // cnt 1
    rd(9, 2'd2, 32'd1);            // R9
    // R1: stop
    wr(2'd0, 32'h0);               // cnt 2
    wait_n(2);
    rd(1, 2'd2, 32'd0);            // R1
    wr(2'd3, 32'h2);
    // R4: free run, ref 2
    wr(2'd1, 32'd2);
    wr(2'd0, RUN);
    wait_n(5);
    rd(4, 2'd2, 32'd5);            // R4 passes ref
    rd(4, 2'd3, 32'h2);            // R4 flag at match
    wait_n(65531);
    rd(4, 2'd2, 32'd0);            // R4 full-width wrap
    // R3 / R8: divide by 16, restart, ref 2
    wr(2'd0, 32'h0);
    wait_n(1);
    wr(2'd0, RUN | RST | DIV16);
    wait_n(15);
    rd(8, 2'd2, 32'd0);            // R8 full first interval
    wait_n(1);
    rd(8, 2'd2, 32'd1);            // R8
    wait_n(15);
    rd(3, 2'd2, 32'd1);            // R3
    wait_n(1);
    rd(3, 2'd2, 32'd2);            // R3
    wait_n(16);
    rd(2, 2'd2, 32'd0);            // R2 with divider
    wait_n(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule